// File: doc/BRIEF.md
# Repeated String Move Engine

This block runs a hardware copy loop that is started by a two-byte command taken from an instruction byte stream. While it waits for a command it accepts bytes one at a time. A repeat-prefix byte followed by a move opcode byte starts a copy. The copy takes three implicit operands from architectural register inputs: a source pointer, a destination pointer and a byte count. None of these operands is carried in the command bytes.

During the copy the engine reads one byte at the source pointer over a byte-wide read port and writes that byte at the destination pointer over a write port. After each byte it moves both pointers up by one and lowers the count by one. It stops when the count reaches zero. The updated pointer and count registers are visible on the outputs at all times, and a one-cycle completion flag marks the end of a copy. Both memory ports use valid/ready handshakes, and either side may stall the engine for any number of cycles.

Top module: `strmv_engine`

## Requirements
- R1: While waiting, a byte 0xF2 accepted on the command stream and then a byte 0xA4 accepted as the next byte start a copy. At the clock edge that accepts 0xA4, the source pointer, destination pointer and count outputs load the values on `src_init`, `dst_init` and `cnt_init`.
- R2: The bytes are copied in ascending address order. Copy k (k counted from 0) reads address src+k and then writes the byte returned by that read to address dst+k.
- R3: Each accepted write increments `src_ptr` and `dst_ptr` by one and decrements `cnt_left` by one. After a copy of N bytes, `src_ptr` equals src+N, `dst_ptr` equals dst+N and `cnt_left` equals 0. The pointers wrap modulo 2^ADDR_W.
- R4: A copy started with a count of zero issues no read request and no write request. `done` is high in the cycle after the clock edge that accepts 0xA4.
- R5: When 0xF2 is followed by any byte other than 0xA4, including a second 0xF2, no copy starts and no pointer changes. `unsupported` is high for one cycle after the edge that accepts the second byte, and the recognizer then waits for a fresh 0xF2.
- R6: While the engine waits for a prefix, any byte other than 0xF2 is accepted and ignored. Such a byte raises no flag, starts no copy and changes no pointer.
- R7: `rd_valid` stays high with a stable `rd_addr` until `rd_ready` is high. `wr_valid` stays high with stable `wr_addr` and `wr_data` until `wr_ready` is high. Stalls on either port never drop a byte or write a byte twice.
- R8: `done` is high for exactly one cycle, in the cycle after the edge of the final write handshake. `cmd_ready` is low while a copy is in progress.
- R9: After reset the pointer and count outputs are zero, `done`, `unsupported`, `rd_valid` and `wr_valid` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Command stream byte |
| cmd_ready | output | 1 | Engine can accept a command byte (idle) |
| src_init | input | ADDR_W | Source pointer register value |
| dst_init | input | ADDR_W | Destination pointer register value |
| cnt_init | input | CNT_W | Byte count register value |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read request accepted |
| rdat_valid | input | 1 | Read data returned |
| rdat | input | 8 | Read data byte |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 8 | Write data byte |
| wr_ready | input | 1 | Write request accepted |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| cnt_left | output | CNT_W | Remaining byte count |
| done | output | 1 | One-cycle completion flag |
| unsupported | output | 1 | One-cycle flag for a prefix not followed by the move opcode |

## Verification
The copy is run with memory that never stalls and with memory whose ready lines and read latency follow a pseudo-random pattern. Comparing the two shows whether a stall can drop or repeat a byte. The test lengths are zero, one, a few, and forty bytes. The zero length separates the no-access path from the loop, and the single byte exercises the last-byte exit on the first iteration. One copy uses pointers with nonzero upper bits, which shows whether the full pointer width is carried. Malformed streams are also sent: a foreign byte on its own, the prefix followed by a wrong byte, and a doubled prefix. These show that only the exact pair starts a copy and that the recognizer recovers afterwards.

// File: rtl/strmv_pkg.sv
// Package: shared encodings for the string move engine.
// Assumes: command bytes are 8 bits wide.
package strmv_pkg;
    localparam logic [7:0] CMD_PREFIX = 8'hF2;
    localparam logic [7:0] CMD_MOVE   = 8'hA4;

    typedef enum logic [0:0] {
        DEC_WAIT_PREFIX = 1'b0,
        DEC_WAIT_OP     = 1'b1
    } dec_state_t;

    typedef enum logic [1:0] {
        CP_IDLE    = 2'd0,
        CP_RD_REQ  = 2'd1,
        CP_RD_WAIT = 2'd2,
        CP_WRITE   = 2'd3
    } cp_state_t;
endpackage

// File: rtl/strmv_decoder.sv
// Module: strmv_decoder
// Recognizes the two-byte move command in the incoming byte stream.
// Assumes: byte_take is high only for bytes accepted while the engine is idle.
// start is combinational in the cycle the opcode byte is taken; bad is a
// registered one-cycle pulse after a prefix followed by a wrong byte.
module strmv_decoder
    import strmv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_take,
    input  logic [7:0] byte_in,
    output logic       start,
    output logic       bad
);
    dec_state_t state;
    logic       bad_q;

    // Start fires when the opcode byte follows the prefix.
    always_comb begin
        start = byte_take && (state == DEC_WAIT_OP) && (byte_in == CMD_MOVE);
    end

    // Track whether a prefix has been seen; flag a prefix with a wrong follower.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DEC_WAIT_PREFIX;
            bad_q <= 1'b0;
        end else begin
            bad_q <= 1'b0;
            if (byte_take) begin
                if (state == DEC_WAIT_PREFIX) begin
                    if (byte_in == CMD_PREFIX) state <= DEC_WAIT_OP;
                end else begin
                    state <= DEC_WAIT_PREFIX;
                    if (byte_in != CMD_MOVE) bad_q <= 1'b1;
                end
            end
        end
    end

    assign bad = bad_q;

    // R5: the flag is only raised after a byte was taken in the opcode state.
    a_r5_bad_after_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |-> ($past(state) == DEC_WAIT_OP) && $past(byte_take));

    // R6: a non-prefix byte while waiting for a prefix leaves the state alone.
    a_r6_ignore_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_take && state == DEC_WAIT_PREFIX && byte_in != CMD_PREFIX)
        |=> (state == DEC_WAIT_PREFIX) && !bad_q);
endmodule

// File: rtl/strmv_copier.sv
// Module: strmv_copier
// Runs the read/write loop over the byte memory ports and holds the
// source pointer, destination pointer and count registers.
// Assumes: read data returns (rdat_valid) only after an accepted read request;
// rdat_valid outside the wait state is ignored.
module strmv_copier
    import strmv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rdat_valid,
    input  logic [7:0]        rdat,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              done,
    output logic              busy
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    cp_state_t  state;
    logic [7:0] data_q;
    logic       done_q;
    logic       wr_fire;

    // Write handshake of the current byte.
    always_comb begin
        wr_fire = (state == CP_WRITE) && wr_ready;
    end

    // Main loop: load operands, request read, await data, write, step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CP_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                CP_IDLE: begin
                    if (start) begin
                        src_q <= src_in;
                        dst_q <= dst_in;
                        cnt_q <= cnt_in;
                        if (cnt_in == '0) done_q <= 1'b1;
                        else              state  <= CP_RD_REQ;
                    end
                end
                CP_RD_REQ: begin
                    if (rd_ready) state <= CP_RD_WAIT;
                end
                CP_RD_WAIT: begin
                    if (rdat_valid) begin
                        data_q <= rdat;
                        state  <= CP_WRITE;
                    end
                end
                CP_WRITE: begin
                    if (wr_fire) begin
                        src_q <= src_q + ADDR_ONE;
                        dst_q <= dst_q + ADDR_ONE;
                        cnt_q <= cnt_q - CNT_ONE;
                        if (cnt_q == CNT_ONE) begin
                            state  <= CP_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= CP_RD_REQ;
                        end
                    end
                end
                default: state <= CP_IDLE;
            endcase
        end
    end

    // Drive the memory ports from the state and the current registers.
    always_comb begin
        rd_valid = (state == CP_RD_REQ);
        rd_addr  = src_q;
        wr_valid = (state == CP_WRITE);
        wr_addr  = dst_q;
        wr_data  = data_q;
        busy     = (state != CP_IDLE);
        done     = done_q;
    end

    // R7: a stalled read request holds its address.
    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));

    // R7: a stalled write request holds address and data.
    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R3: every accepted write steps the count down by one.
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (cnt_q == $past(cnt_q) - CNT_ONE)
                                   && (src_q == $past(src_q) + ADDR_ONE));

    // R4: a zero-length command completes at once with no request.
    a_r4_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cnt_in == '0) |=> done && !rd_valid && !wr_valid);

    // R8: completion is a single-cycle pulse with the count exhausted.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == '0) && !busy);
endmodule

// File: rtl/strmv_engine.sv
// Module: strmv_engine (top)
// Repeated string move engine: command recognizer feeding the copy loop.
// Assumes: src_init/dst_init/cnt_init hold the architectural register values
// when the opcode byte is accepted; command bytes are taken only while idle.
module strmv_engine #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rdat_valid,
    input  logic [7:0]        rdat,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic [CNT_W-1:0]  cnt_left,
    output logic              done,
    output logic              unsupported
);
    logic busy;
    logic take;
    logic start;

    // Accept command bytes only while no copy is running.
    always_comb begin
        cmd_ready = !busy;
        take      = cmd_valid && cmd_ready;
    end

    strmv_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_take(take),
        .byte_in (cmd_byte),
        .start   (start),
        .bad     (unsupported)
    );

    strmv_copier #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_in    (src_init),
        .dst_in    (dst_init),
        .cnt_in    (cnt_init),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .rd_ready  (rd_ready),
        .rdat_valid(rdat_valid),
        .rdat      (rdat),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .src_q     (src_ptr),
        .dst_q     (dst_ptr),
        .cnt_q     (cnt_left),
        .done      (done),
        .busy      (busy)
    );

    // R8: no command byte is taken while a memory request is outstanding.
    a_r8_no_cmd_when_copying: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> !cmd_ready);

    // R5: a rejected command leaves the pointers untouched.
    a_r5_bad_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> $stable(src_ptr) && $stable(dst_ptr) && $stable(cnt_left));
endmodule

// File: tb/strmv_engine_tb_top.sv
module strmv_engine_tb_top;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_byte = 8'h00;
    logic          cmd_ready;
    logic [AW-1:0] src_init = '0;
    logic [AW-1:0] dst_init = '0;
    logic [CW-1:0] cnt_init = '0;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic          rd_ready = 1'b0;
    logic          rdat_valid = 1'b0;
    logic [7:0]    rdat = 8'h00;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] src_ptr;
    logic [AW-1:0] dst_ptr;
    logic [CW-1:0] cnt_left;
    logic          done;
    logic          unsupported;

    always #5 clk = ~clk;

    strmv_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (.*);

    int         n_checks = 0;
    int         n_fail = 0;
    int         rd_count = 0;
    int         done_count = 0;
    logic [7:0] mem [0:255];
    logic [AW-1:0] exp_a [$];
    logic [7:0]    exp_d [$];
    int         stall_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic       resp_pend = 1'b0;
    int         resp_dly = 0;
    logic [7:0] resp_byte = 8'h00;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Memory model and scoreboard monitor, acting between clock edges.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rdat_valid = 1'b0;
        if (resp_pend) begin
            if (resp_dly == 0) begin
                rdat_valid = 1'b1;
                rdat = resp_byte;
                resp_pend = 1'b0;
            end else resp_dly--;
        end
        rd_ready = (stall_mode == 0) ? 1'b1 : lfsr[0];
        wr_ready = (stall_mode == 0) ? 1'b1 : lfsr[3];
        if (rd_valid && rd_ready) begin
            rd_count++;
            resp_pend = 1'b1;
            resp_dly  = (stall_mode == 0) ? 0 : int'(lfsr[6:5]);
            resp_byte = mem[rd_addr[7:0]];
        end
        if (wr_valid && wr_ready) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R7 extra write", 32'(wr_addr), 32'hFFFF_FFFF);
            end else begin
                logic [AW-1:0] ea;
                logic [7:0]    ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                check(wr_addr == ea, "R2 write address", 32'(wr_addr), 32'(ea));
                check(wr_data == ed, "R2 write data", 32'(wr_data), 32'(ed));
            end
            mem[wr_addr[7:0]] = wr_data;
        end
        if (done) done_count++;
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_copy(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n, input int mode);
        int dc;
        stall_mode = mode;
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] sa;
            sa = s + AW'(i);
            mem[sa[7:0]] = 8'(i * 37 + n + int'(s));
            exp_a.push_back(d + AW'(i));
            exp_d.push_back(mem[sa[7:0]]);
        end
        src_init = s; dst_init = d; cnt_init = CW'(n);
        dc = done_count;
        send_byte(8'hF2);
        send_byte(8'hA4);
        check(src_ptr == s || n > 0, "R1 source loaded", 32'(src_ptr), 32'(s));
        if (n > 0) check(cmd_ready == 1'b0, "R8 ready low while copying", 32'(cmd_ready), 0);
        for (int w = 0; w < 20000 && !done; w++) @(negedge clk);
        check(done == 1'b1, "R8 done seen", 32'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", 32'(done), 0);
        check(done_count == dc + 1, "R8 single done pulse", 32'(done_count - dc), 1);
        check(exp_a.size() == 0, "R7 no byte lost", 32'(exp_a.size()), 0);
        check(src_ptr == s + AW'(n), "R3 final source", 32'(src_ptr), 32'(s + AW'(n)));
        check(dst_ptr == d + AW'(n), "R3 final destination", 32'(dst_ptr), 32'(d + AW'(n)));
        check(cnt_left == '0, "R3 final count", 32'(cnt_left), 0);
        exp_a.delete();
        exp_d.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(cmd_ready == 1'b1, "R9 ready", 32'(cmd_ready), 1);
        check(!rd_valid && !wr_valid, "R9 no requests", 32'({rd_valid, wr_valid}), 0);
        check(!done && !unsupported, "R9 flags low", 32'({done, unsupported}), 0);
        check(src_ptr == '0 && dst_ptr == '0 && cnt_left == '0, "R9 registers zero", 32'(cnt_left), 0);

        // R1 R2 R3: plain copy without stalls
        run_copy(16'h0010, 16'h0080, 5, 0);
        // R7: copy under random stalls and latency
        run_copy(16'h0020, 16'h0090, 9, 1);
        run_copy(16'h0000, 16'h00A0, 40, 1);
        // R3: upper pointer bits carried through
        run_copy(16'h3F40, 16'h0150, 3, 1);
        // single-byte copy, last-byte exit on first iteration
        run_copy(16'h0060, 16'h0070, 1, 1);

        // R4: zero-length copy
        begin
            int rc;
            rc = rd_count;
            src_init = 16'h0033; dst_init = 16'h0044; cnt_init = '0;
            send_byte(8'hF2);
            send_byte(8'hA4);
            check(done == 1'b1, "R4 done right after opcode", 32'(done), 1);
            check(src_ptr == 16'h0033 && dst_ptr == 16'h0044, "R4 pointers loaded unchanged", 32'(src_ptr), 32'h33);
            repeat (3) @(negedge clk);
            check(rd_count == rc, "R4 no read issued", 32'(rd_count - rc), 0);
        end

        // R6: stray bytes while waiting for a prefix
        src_init = 16'h0011; cnt_init = CW'(4);
        send_byte(8'h90);
        check(unsupported == 1'b0, "R6 no flag on stray", 32'(unsupported), 0);
        send_byte(8'hA4);
        check(unsupported == 1'b0, "R6 lone opcode ignored", 32'(unsupported), 0);
        check(cmd_ready == 1'b1 && src_ptr == 16'h0033, "R6 no copy started", 32'(src_ptr), 32'h33);

        // R5: prefix followed by a wrong byte
        send_byte(8'hF2);
        send_byte(8'h33);
        check(unsupported == 1'b1, "R5 flag raised", 32'(unsupported), 1);
        check(src_ptr == 16'h0033 && cmd_ready, "R5 no copy", 32'(src_ptr), 32'h33);
        @(negedge clk);
        check(unsupported == 1'b0, "R5 flag one cycle", 32'(unsupported), 0);
        // R5: doubled prefix, then the opcode on its own must not start
        send_byte(8'hF2);
        send_byte(8'hF2);
        check(unsupported == 1'b1, "R5 doubled prefix flagged", 32'(unsupported), 1);
        send_byte(8'hA4);
        check(cmd_ready == 1'b1 && cnt_left == '0, "R5 opcode after doubled prefix ignored", 32'(cnt_left), 0);
        // R5: recovery, a proper command still works
        run_copy(16'h00D0, 16'h00E0, 4, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule